// File: doc/BRIEF.md
# Global-History Taken/Not-Taken Predictor

The block guesses whether a conditional branch is taken. For each lookup it combines the fetch address with a register of recent branch outcomes and uses the result as an index into a table of 2-bit saturating counters. A counter in its upper half means taken. The block stores no targets. Which fetched instructions are branches, and where they go, is decided elsewhere. The lookup path has three stages. The first stage registers the hash. The second reads the counter memory while the front end decodes. The third registers the direction and counter at the start of the following stage, so a redirect from this block arrives one cycle later than it would from a same-cycle design.

The counter table is logically tall and two bits wide. It is stored as a square single-port memory. Each row holds many counters, and the low index bits pick one counter out of the row that is read. The front end returns each prediction's index, the counter value it saw and the history it used, together with the resolved outcome. The block then writes the stepped counter back. Lookups own the memory port. Updates wait in a one-entry holding register until the port is free. A misprediction update also rebuilds the history from the returned snapshot.

Top module: `ghist_predictor`

## Requirements
- R1: After synchronous reset, `pred_valid` is 0 and `upd_ready` is 1. Every counter reads as 1 (weakly not-taken) until it is written.
- R2: The table index is `lk_pc[IDX_W+1:2]` XOR the history register as it stood at the edge that sampled the lookup. `pred_idx` reports this index and `pred_hist` reports that history.
- R3: A lookup sampled at edge k produces exactly one prediction, registered at edge k+2, with `pred_valid` high for one cycle. No prediction appears without a lookup.
- R4: `pred_taken` is 1 exactly when the counter read for the prediction is 2 or 3. `pred_ctr` carries that counter.
- R5: An accepted update writes the returned counter plus one if taken, or minus one if not taken. The result saturates at 3 and at 0. Later lookups of that index see the new value.
- R6: At the edge where a prediction is registered, the history shifts left by one bit and the predicted direction enters at bit 0.
- R7: An accepted update with `upd_mispred` = 1 sets the history to `{upd_hist[IDX_W-2:0], upd_taken}`. This overrides a shift at the same edge.
- R8: A lookup read wins the memory port. An accepted update is held, and `upd_ready` stays 0, until the first edge at which no lookup occupies the read stage; it is written at that edge. An update offered while `upd_ready` is 0 is ignored.
- R9: Writing one counter leaves the other counters that share its memory row unchanged. This includes the first write to a row never written before, whose other counters keep reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request for a conditional branch |
| lk_pc | input | PC_W | Fetch address of the lookup |
| pred_valid | output | 1 | Registered prediction available |
| pred_taken | output | 1 | Predicted direction |
| pred_ctr | output | 2 | Counter value behind the prediction |
| pred_idx | output | IDX_W | Table index used |
| pred_hist | output | IDX_W | History used in the hash |
| upd_valid | input | 1 | Resolved-branch update request |
| upd_ready | output | 1 | Holding register free; update accepted |
| upd_idx | input | IDX_W | Index returned from the prediction |
| upd_ctr | input | 2 | Counter value returned from the prediction |
| upd_taken | input | 1 | Resolved direction |
| upd_mispred | input | 1 | Restore history from snapshot |
| upd_hist | input | IDX_W | History snapshot of the resolved branch |

## Verification
Directed lookups on a single fetch address separate the hash inputs. A repeated address lands on a new index once the history has moved, and it lands on a neighbour in the same memory row, which exposes cross-talk between counters. Updates that carry counters 3 and 0 push against both saturation limits. A rollback with a hand-chosen snapshot shows whether the restore or the shift wins. A stream of lookups that overlaps a pending update shows whether the read keeps priority and the write is deferred. A long seeded random mix of lookups, updates and rollbacks then compares every output, every cycle, against a cycle-level model of the requirements.

// File: rtl/ghist_pkg.sv
package ghist_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'd1;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/ghist_hash.sv
module ghist_hash #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PC_LSB = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[PC_LSB +: IDX_W] ^ hist;
endmodule

// File: rtl/ghist_ctr_ram.sv
module ghist_ctr_ram
  import ghist_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int COL_LG = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  localparam int ROW_LG   = IDX_W - COL_LG;
  localparam int ROWS     = 1 << ROW_LG;
  localparam int LANES    = 1 << COL_LG;
  localparam int ROW_BITS = 2 * LANES;

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROWS-1:0]     row_vld;
  logic [ROW_BITS-1:0] rd_row_q;
  logic                rd_vld_q;
  logic [COL_LG-1:0]   rd_col_q;

  logic [ROW_LG-1:0]   rd_row, wr_row;
  logic [COL_LG-1:0]   rd_col, wr_col;
  logic [ROW_BITS-1:0] wr_data;
  logic [LANES-1:0]    lane_we;

  assign rd_row = rd_idx[IDX_W-1:COL_LG];
  assign rd_col = rd_idx[COL_LG-1:0];
  assign wr_row = wr_idx[IDX_W-1:COL_LG];
  assign wr_col = wr_idx[COL_LG-1:0];

  // a fresh row is written whole so its untouched lanes start at CTR_INIT
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l]          = (wr_col == COL_LG'(l)) || !row_vld[wr_row];
    assign wr_data[2*l +: 2]   = (wr_col == COL_LG'(l)) ? wr_ctr : CTR_INIT;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l]) mem[wr_row][2*l +: 2] <= wr_data[2*l +: 2];
      end
    end
    if (rd_en) rd_row_q <= mem[rd_row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_vld  <= '0;
      rd_vld_q <= 1'b0;
      rd_col_q <= '0;
    end else begin
      if (wr_en) row_vld[wr_row] <= 1'b1;
      if (rd_en) begin
        rd_vld_q <= row_vld[rd_row];
        rd_col_q <= rd_col;
      end
    end
  end

  assign rd_ctr = rd_vld_q ? rd_row_q[{rd_col_q, 1'b0} +: 2] : CTR_INIT;
endmodule

// File: rtl/ghist_upd_buf.sv
module ghist_upd_buf
  import ghist_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  ctr_t             in_ctr,
  input  logic             in_taken,
  input  logic             port_free,
  output logic             ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_ctr
);
  logic             held_q;
  logic [IDX_W-1:0] idx_q;
  ctr_t             ctr_q;
  logic             taken_q;

  assign ready  = !held_q;
  assign wr_en  = held_q && port_free;
  assign wr_idx = idx_q;
  assign wr_ctr = ctr_step(ctr_q, taken_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      idx_q   <= '0;
      ctr_q   <= CTR_INIT;
      taken_q <= 1'b0;
    end else if (in_valid && !held_q) begin
      held_q  <= 1'b1;
      idx_q   <= in_idx;
      ctr_q   <= in_ctr;
      taken_q <= in_taken;
    end else if (wr_en) begin
      held_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor
  import ghist_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int COL_LG = 5,
  parameter int PC_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [1:0]       pred_ctr,
  output logic [IDX_W-1:0] pred_idx,
  output logic [IDX_W-1:0] pred_hist,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [1:0]       upd_ctr,
  input  logic             upd_taken,
  input  logic             upd_mispred,
  input  logic [IDX_W-1:0] upd_hist
);
  logic [IDX_W-1:0] ghist_q;
  logic [IDX_W-1:0] hash_idx;

  logic             s1_v, s2_v;
  logic [IDX_W-1:0] s1_idx, s1_hist, s2_idx, s2_hist;
  ctr_t             rd_ctr;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  ctr_t             wr_ctr;
  logic             restore;

  ghist_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_hash (
    .pc(lk_pc), .hist(ghist_q), .idx(hash_idx)
  );

  ghist_ctr_ram #(.IDX_W(IDX_W), .COL_LG(COL_LG)) u_ram (
    .clk(clk), .rst(rst),
    .rd_en(s1_v), .rd_idx(s1_idx), .rd_ctr(rd_ctr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ctr(wr_ctr)
  );

  ghist_upd_buf #(.IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst),
    .in_valid(upd_valid), .in_idx(upd_idx), .in_ctr(upd_ctr), .in_taken(upd_taken),
    .port_free(!s1_v), .ready(upd_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ctr(wr_ctr)
  );

  assign restore = upd_valid && upd_ready && upd_mispred;

  // stage 1: registered hash; stage 2: array read; stage 3: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_idx  <= '0;
      s1_hist <= '0;
      s2_v    <= 1'b0;
      s2_idx  <= '0;
      s2_hist <= '0;
    end else begin
      s1_v    <= lk_valid;
      s1_idx  <= hash_idx;
      s1_hist <= ghist_q;
      s2_v    <= s1_v;
      s2_idx  <= s1_idx;
      s2_hist <= s1_hist;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_ctr   <= '0;
      pred_idx   <= '0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= s2_v;
      if (s2_v) begin
        pred_taken <= rd_ctr[1];
        pred_ctr   <= rd_ctr;
        pred_idx   <= s2_idx;
        pred_hist  <= s2_hist;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ghist_q <= '0;
    else if (restore) ghist_q <= {upd_hist[IDX_W-2:0], upd_taken};
    else if (s2_v)    ghist_q <= {ghist_q[IDX_W-2:0], rd_ctr[1]};
  end
endmodule

// File: rtl/ghist_predictor_chk.sv
module ghist_predictor_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             pred_valid,
  input logic             pred_taken,
  input logic [1:0]       pred_ctr,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             upd_taken,
  input logic             upd_mispred,
  input logic [IDX_W-1:0] upd_hist,
  input logic             s1_v,
  input logic             s2_v,
  input logic             s2_tk,
  input logic [IDX_W-1:0] ghist
);
  logic rollback;
  assign rollback = upd_valid && upd_ready && upd_mispred;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!pred_valid && upd_ready));

  // R3
  pred_origin_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lk_valid, 3));

  // R4
  dir_from_ctr_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_taken == pred_ctr[1]));

  // R8
  accept_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_ready) |=> !upd_ready);

  // R8
  read_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_ready && s1_v) |=> !upd_ready);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !rollback) |=> (ghist == {$past(ghist[IDX_W-2:0]), $past(s2_tk)}));

  // R7
  hist_restore_chk: assert property (@(posedge clk) disable iff (rst)
    rollback |=> (ghist == {$past(upd_hist[IDX_W-2:0]), $past(upd_taken)}));
endmodule

bind ghist_predictor ghist_predictor_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_ctr(pred_ctr),
  .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_taken(upd_taken),
  .upd_mispred(upd_mispred), .upd_hist(upd_hist),
  .s1_v(s1_v), .s2_v(s2_v), .s2_tk(rd_ctr[1]), .ghist(ghist_q)
);

// File: tb/ghist_predictor_tb.sv
module ghist_predictor_tb;
  localparam int PC_W  = 32;
  localparam int IDX_W = 10;
  localparam int NENT  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             lk_v = 0;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             up_v = 0, up_tk = 0, up_mis = 0;
  logic [IDX_W-1:0] up_idx = '0, up_hist = '0;
  logic [1:0]       up_ctr = '0;

  logic             pred_valid, pred_taken, upd_ready;
  logic [1:0]       pred_ctr;
  logic [IDX_W-1:0] pred_idx, pred_hist;

  ghist_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_v), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_ctr(pred_ctr),
    .pred_idx(pred_idx), .pred_hist(pred_hist),
    .upd_valid(up_v), .upd_ready(upd_ready), .upd_idx(up_idx), .upd_ctr(up_ctr),
    .upd_taken(up_tk), .upd_mispred(up_mis), .upd_hist(up_hist)
  );

  int n_cmp = 0, n_bad = 0;

  // model state
  logic [1:0]       tbl [NENT];
  logic [IDX_W-1:0] m_ghist;
  logic             m_s1_v, m_s2_v, m_buf_v, m_buf_tk;
  logic [IDX_W-1:0] m_s1_idx, m_s1_hist, m_s2_idx, m_s2_hist, m_buf_idx;
  logic [1:0]       m_s2_ctr, m_buf_ctr;
  logic             m_pv, m_pt;
  logic [1:0]       m_pc;
  logic [IDX_W-1:0] m_pi, m_ph;

  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) tbl[i] = 2'd1;
    m_ghist = '0; m_s1_v = 0; m_s2_v = 0; m_buf_v = 0; m_pv = 0;
    m_s1_idx = '0; m_s1_hist = '0; m_s2_idx = '0; m_s2_hist = '0; m_s2_ctr = '0;
  endtask

  task automatic model_step();
    logic             acc;
    logic [IDX_W-1:0] g0;
    logic [1:0]       n_ctr;
    acc   = up_v && !m_buf_v;
    g0    = m_ghist;
    n_ctr = tbl[m_s1_idx];
    if (m_buf_v && !m_s1_v) begin
      tbl[m_buf_idx] = sat(m_buf_ctr, m_buf_tk);
      m_buf_v = 0;
    end
    m_pv = m_s2_v;
    if (m_s2_v) begin
      m_pt = m_s2_ctr[1]; m_pc = m_s2_ctr; m_pi = m_s2_idx; m_ph = m_s2_hist;
    end
    if (acc && up_mis)  m_ghist = {up_hist[IDX_W-2:0], up_tk};
    else if (m_s2_v)    m_ghist = {g0[IDX_W-2:0], m_s2_ctr[1]};
    m_s2_v = m_s1_v; m_s2_idx = m_s1_idx; m_s2_hist = m_s1_hist; m_s2_ctr = n_ctr;
    m_s1_v = lk_v; m_s1_idx = lk_pc[IDX_W+1:2] ^ g0; m_s1_hist = g0;
    if (acc) begin
      m_buf_v = 1; m_buf_idx = up_idx; m_buf_ctr = up_ctr; m_buf_tk = up_tk;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 pred_valid", pred_valid, m_pv);
    if (m_pv) begin
      chk("R4 pred_taken", pred_taken, m_pt);
      chk("R5 pred_ctr", pred_ctr, m_pc);
      chk("R2 pred_idx", pred_idx, m_pi);
      chk("R6 pred_hist", pred_hist, m_ph);
    end
    chk("R8 upd_ready", upd_ready, !m_buf_v);
  endtask

  task automatic idle(int n);
    lk_v = 0; up_v = 0;
    repeat (n) cyc();
  endtask

  task automatic look(logic [PC_W-1:0] pc);
    lk_v = 1; lk_pc = pc; cyc();
    lk_v = 0; cyc(); cyc();
  endtask

  task automatic look_idx(logic [IDX_W-1:0] t);
    look(PC_W'({t ^ m_ghist, 2'b00}));
  endtask

  task automatic upd(logic [IDX_W-1:0] i, logic [1:0] c, logic t, logic mis, logic [IDX_W-1:0] h);
    up_v = 1; up_idx = i; up_ctr = c; up_tk = t; up_mis = mis; up_hist = h;
    cyc();
    up_v = 0; up_mis = 0;
  endtask

  initial begin
    #(100000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_0042));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cyc();
    chk("R1 reset pred_valid", pred_valid, 0);
    chk("R1 reset upd_ready", upd_ready, 1);

    // fresh entry, history zero
    look(32'h40);
    chk("R1 fresh ctr", pred_ctr, 1);
    chk("R2 idx", pred_idx, 10'h010);
    chk("R2 hist", pred_hist, 0);
    chk("R4 weak not-taken", pred_taken, 0);

    upd(10'h010, 2'd1, 1'b1, 1'b0, '0);
    idle(2);
    look(32'h40);
    chk("R5 incremented", pred_ctr, 2);
    chk("R4 taken at 2", pred_taken, 1);

    // history now 1: same pc hits row neighbour 0x011
    look(32'h40);
    chk("R6 shifted hist", pred_hist, 10'h001);
    chk("R2 idx with hist", pred_idx, 10'h011);
    chk("R9 neighbour intact", pred_ctr, 1);

    upd(10'h011, 2'd1, 1'b1, 1'b1, 10'h155);
    idle(2);
    look(32'h0);
    chk("R7 restored hist", pred_hist, 10'h2AB);
    chk("R7 restored idx", pred_idx, 10'h2AB);

    upd(10'h010, 2'd3, 1'b1, 1'b0, '0);
    idle(2);
    look_idx(10'h010);
    chk("R5 saturate high", pred_ctr, 3);
    upd(10'h020, 2'd0, 1'b0, 1'b0, '0);
    idle(2);
    look_idx(10'h020);
    chk("R5 saturate low", pred_ctr, 0);

    upd(10'h3E3, 2'd1, 1'b1, 1'b0, '0);
    idle(2);
    look_idx(10'h3E1);
    chk("R9 fresh row lane", pred_ctr, 1);
    look_idx(10'h3E3);
    chk("R9 written lane", pred_ctr, 2);

    // read priority: update arrives during a lookup stream
    lk_v = 1; lk_pc = 32'h100;
    up_v = 1; up_idx = 10'h030; up_ctr = 2'd1; up_tk = 1; up_mis = 0;
    cyc();
    up_v = 0;
    for (int i = 0; i < 5; i++) begin
      lk_pc = PC_W'((i + 7) * 4);
      up_v = 1; up_idx = 10'h031; up_ctr = 2'd3; up_tk = 0;
      cyc();
      up_v = 0;
      chk("R8 held during reads", upd_ready, 0);
    end
    idle(1);
    chk("R8 still held", upd_ready, 0);
    idle(1);
    chk("R8 drained", upd_ready, 1);
    idle(3);
    look_idx(10'h030);
    chk("R8 deferred write", pred_ctr, 2);
    look_idx(10'h031);
    chk("R8 ignored offer", pred_ctr, 1);

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      lk_v   = ($urandom % 2) == 0;
      lk_pc  = PC_W'($urandom_range(0, 255) << 2);
      up_v   = ($urandom % 3) == 0;
      up_idx = (($urandom % 2) == 0) ? m_pi : IDX_W'($urandom);
      up_ctr = 2'($urandom);
      up_tk  = 1'($urandom);
      up_mis = ($urandom % 8) == 0;
      up_hist = IDX_W'($urandom);
      cyc();
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule